// File: doc/BRIEF.md
# Write-only two-wire control register slave

This block is a slave on a two-wire serial control bus that only accepts writes. The bus clock and data lines arrive as plain inputs and are sampled on the system clock. The block finds the START and STOP conditions and shifts in whole bytes. It acknowledges a transfer only when the first byte matches one fixed device byte with the write flag clear. The data bytes that follow fill a small bank of 8-bit control registers. The bank drives per-output enable bits for a clock buffer.

There is no command or sub-address byte. Every transaction fills the bank from register 0 upward in arrival order, up to a fixed maximum count. Traffic aimed at another address, read requests and bytes past the limit are not acknowledged and do not change any register. Registers take their default value only at reset. The data line is driven through an active-high pull-down enable and is never driven high.

Top module: `wr_ctl_slave`

## Requirements
- R1: A falling SDA edge while SCL is high starts a transaction. A rising SDA edge while SCL is high ends it. After a STOP, clocked bytes that are not preceded by a START change no register.
- R2: Each byte is received MSB first: the first bit clocked after the START or ACK becomes bit 7 of the byte.
- R3: An address byte equal to DEV_ADDR (default 0xD2; bit 0 = 0 means write) is acknowledged. The acknowledge is sda_pull high throughout the ninth SCL high phase.
- R4: Data bytes after an accepted address go to register 0, 1, 2 and onward in arrival order, and each one is acknowledged. Register k appears on ctl_out[8k+7:8k].
- R5: At most NREG (default 10) data bytes are accepted per transaction. Every further byte is neither acknowledged nor stored.
- R6: An address byte other than DEV_ADDR, including the read form 0xD3, gets no acknowledge, and the data bytes that follow it get none either. All registers keep their contents.
- R7: Reset loads RST_VAL (default 0xFF) into every register. START and STOP never reload it, so registers that a transaction does not reach keep their previous values.
- R8: A START in the middle of a byte aborts that byte. Decoding restarts at the address byte, and registers completed before the abort keep their new values.
- R9: sda_pull is never high during the SCL high phase of a data bit. It is released after the SCL falling edge that ends the acknowledge slot.
- R10: Every accepted transaction, including one after a repeated START, begins writing at register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset, loads register defaults |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the wire, asynchronous |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line, high pulls low |
| ctl_out | output | NREG*8 | Concatenated control registers, register k at bits 8k+7:8k |

## Verification
The tenth register store and the limit count reaching its maximum happen on the same SCL edge. The acknowledge decision for that byte and the refusal of the next byte therefore depend on one counter update. The bench sweeps transactions of 1 to 12 data bytes and judges, byte by byte, the sampled acknowledge and every register against a model that stops storing after ten bytes. It also provokes a repeated START in the middle of a byte, right after completed stores, and checks that the finished bytes are kept while the aborted byte is lost.

// File: rtl/wr_ctl_slave.sv
module wr_ctl_slave #(
  parameter int          NREG     = 10,
  parameter logic [7:0]  DEV_ADDR = 8'hD2,
  parameter logic [7:0]  RST_VAL  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [NREG*8-1:0] ctl_out
);
  localparam int IW = $clog2(NREG + 1);
  localparam logic [IW-1:0] NMAX = IW'(NREG);
  localparam logic [1:0] S_IDLE = 2'd0, S_ADDR = 2'd1, S_DATA = 2'd2, S_IGN = 2'd3;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_d, sda_d;
  logic [1:0]    st;
  logic [3:0]    bcnt;
  logic [6:0]    shr;
  logic [IW-1:0] idx;
  logic          acc;

  wire scl_s    = scl_sy[1];
  wire sda_s    = sda_sy[1];
  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire active   = (st == S_ADDR) || (st == S_DATA);
  wire ignoring = (st == S_IGN);
  wire [7:0] byte_now = {shr, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy   <= 2'b11;
      sda_sy   <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      st       <= S_IDLE;
      bcnt     <= 4'd0;
      shr      <= 7'd0;
      idx      <= '0;
      acc      <= 1'b0;
      sda_pull <= 1'b0;
      ctl_out  <= {NREG{RST_VAL}};
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (start) begin
        st       <= S_ADDR;
        bcnt     <= 4'd0;
        idx      <= '0;
        acc      <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop) begin
        st       <= S_IDLE;
        bcnt     <= 4'd0;
        sda_pull <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (bcnt < 4'd8) begin
            shr  <= byte_now[6:0];
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd7) begin
              if (st == S_ADDR) begin
                acc <= (byte_now == DEV_ADDR);
              end else if (idx < NMAX) begin
                acc <= 1'b1;
                idx <= idx + 1'b1;
                for (int k = 0; k < NREG; k++)
                  if (idx == IW'(k)) ctl_out[k*8 +: 8] <= byte_now;
              end else begin
                acc <= 1'b0;
              end
            end
          end else if (bcnt == 4'd8) begin
            bcnt <= 4'd9;
          end
        end else if (scl_fall) begin
          if (bcnt == 4'd8) begin
            sda_pull <= acc;
          end else if (bcnt == 4'd9) begin
            sda_pull <= 1'b0;
            bcnt     <= 4'd0;
            st       <= acc ? S_DATA : S_IGN;
          end
        end
      end
    end
  end
endmodule

// File: rtl/wr_ctl_slave_chk.sv
module wr_ctl_slave_chk #(
  parameter int NREG = 10,
  parameter int IW   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              start,
  input logic              ignoring,
  input logic [3:0]        bcnt,
  input logic [IW-1:0]     idx,
  input logic              sda_pull,
  input logic [NREG*8-1:0] ctl_out
);
  a_r9_pull_in_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  a_r5_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(NREG));
  a_r6_ignore_holds_regs: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |=> $stable(ctl_out));
  a_r6_no_pull_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_pull);
  a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bcnt == 4'd0 && !sda_pull));
  a_r2_bit_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd9);
endmodule

bind wr_ctl_slave wr_ctl_slave_chk #(.NREG(NREG), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start(start), .ignoring(ignoring),
  .bcnt(bcnt), .idx(idx), .sda_pull(sda_pull), .ctl_out(ctl_out)
);

// File: tb/sim_wr_ctl_slave.sv
module sim_wr_ctl_slave;
  localparam int CLK_NS = 10;
  localparam int H = 10;
  localparam int NREG = 10;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic sda_pull;
  logic [NREG*8-1:0] ctl_out;
  wire sda_line = msda & ~sda_pull;

  int nvec = 0, nbad = 0, pull_err = 0;
  logic [7:0] exp_r [NREG];

  always #(CLK_NS/2) clk = ~clk;

  wr_ctl_slave u0 (.clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
                   .sda_pull(sda_pull), .ctl_out(ctl_out));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    nvec++;
    if (act !== expv) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic m_start();
    msda = 1'b1; wt(H); scl = 1'b1; wt(H); msda = 1'b0; wt(H); scl = 1'b0; wt(H/2);
  endtask

  task automatic m_stop();
    msda = 1'b0; wt(H); scl = 1'b1; wt(H); msda = 1'b1; wt(H);
  endtask

  task automatic m_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      msda = b[i]; wt(H); scl = 1'b1; wt(H/2);
      if (sda_pull) pull_err++;
      wt(H/2); scl = 1'b0; wt(H/2);
    end
  endtask

  task automatic m_byte(input logic [7:0] b, output logic ack);
    m_bits(b, 8);
    msda = 1'b1; wt(H); scl = 1'b1; wt(H/2);
    ack = ~sda_line;
    wt(H/2); scl = 1'b0; wt(H/2);
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < NREG; k++) chk(req, 32'(ctl_out[k*8 +: 8]), 32'(exp_r[k]));
  endtask

  initial begin
    #(CLK_NS * 190000);
    nbad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] a, d;
    wt(4); rst_n = 1'b1; wt(4);
    for (int k = 0; k < NREG; k++) exp_r[k] = 8'hFF;
    chk_regs("R7 reset");
    chk("R9 reset pull", 32'(sda_pull), 0);

    for (int n = 1; n <= 12; n++) begin
      m_start();
      m_byte(8'hD2, ack);
      chk("R3 addr ack", 32'(ack), 1);
      for (int k = 0; k < n; k++) begin
        d = 8'((n * 37 + k * 11 + 5) ^ (k << 4));
        m_byte(d, ack);
        chk(k < NREG ? "R4 data ack" : "R5 overflow nack", 32'(ack), k < NREG ? 1 : 0);
        if (k < NREG) exp_r[k] = d;
      end
      m_stop();
      wt(4);
      chk_regs("R4 R5 R7 R10 regs");
    end

    for (int j = 0; j < 10; j++) begin
      a = (j < 8) ? (8'hD2 ^ 8'(1 << j)) : (j == 8 ? 8'h00 : 8'hFF);
      m_start();
      m_byte(a, ack);
      chk("R6 bad addr nack", 32'(ack), 0);
      m_byte(8'h5A, ack);
      chk("R6 data nack", 32'(ack), 0);
      m_stop();
      wt(4);
      chk_regs("R6 regs kept");
    end

    m_byte(8'h11, ack);
    m_byte(8'h22, ack);
    wt(4);
    chk_regs("R1 no start ignored");

    m_start();
    m_byte(8'hD2, ack);
    m_byte(8'hA5, ack); exp_r[0] = 8'hA5;
    m_byte(8'h3C, ack); exp_r[1] = 8'h3C;
    m_bits(8'hF0, 4);
    m_start();
    m_byte(8'hD2, ack);
    chk("R8 restart addr ack", 32'(ack), 1);
    m_byte(8'h96, ack); exp_r[0] = 8'h96;
    chk("R10 restart data ack", 32'(ack), 1);
    m_stop();
    wt(4);
    chk_regs("R8 R10 repeated start");

    chk("R9 no pull in data bits", 32'(pull_err), 0);
    wt(4);
    chk("R9 released", 32'(sda_pull), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule